// File: doc/BRIEF.md
# Serial Flash Sector Lock Register

This block holds the volatile per-sector protection state of a serial NOR flash controller. It listens to the SPI mode-0 command stream (chip select, serial clock, one data input) and recognises three commands: write enable (`0x06`), write lock field (`0xE5`) and read lock field (`0xE8`). Each sector owns a two-bit field. One bit blocks program and erase in that sector. The other bit, once set, freezes the field until the next reset. The block drives one inhibit line per sector toward the array engine. It also returns the addressed field on a serial data-out line.

A lock write has a fixed layout: an 8-bit opcode, a 24-bit address sent MSB first, and one data byte. It is 40 rising SCK edges in all. It takes effect only when chip select returns high right after the last data bit. It also needs the write-enable latch to be set and the array engine to be idle at that moment. The write has no busy period. A successful write clears the latch at once. The SPI pins are sampled by the system clock and must already be synchronised to it. SCK must stay low or high for at least two system clocks at a time.

Top module: `spi_sector_lock`

## Requirements
- R1: After reset every lock field is 00, the write-enable latch is clear, every `sector_inhibit` bit is 0 and `spi_miso` is 0.
- R2: A frame of exactly 8 SCK rising edges carrying opcode `0x06`, ended by chip select rising, sets the write-enable latch.
- R3: A frame of exactly 40 edges with opcode `0xE5`, ended by chip select rising while the latch is set and `array_busy` is 0, loads data bits [1:0] into the field of the sector given by address bits [19:16]. All other address bits are ignored. The same event clears the latch.
- R4: A lock write that arrives while the latch is clear changes no field.
- R5: A lock write frame of any length other than 40 edges changes no field and leaves the latch unchanged.
- R6: A lock write that ends while `array_busy` is 1 changes no field and leaves the latch unchanged.
- R7: `sector_inhibit[i]` equals bit 0 (write lock) of sector i's field. It changes only after chip select has risen.
- R8: When bit 1 (lock down) of a field is 1, later writes cannot change either bit of that field until reset. Such a write still clears the latch.
- R9: After opcode `0xE8` and three address bytes, `spi_miso` shifts out `{6'b000000, lock down, write lock}` of the addressed sector, MSB first. Each bit is changed after an SCK falling edge and is valid at the next rising edge, for frame bits 32 to 39. While chip select is high, `spi_miso` is 0.
- R10: A frame with any other opcode changes no field and no latch state.
- R11: Data bits [7:2] of a lock write are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| spi_cs_n | input | 1 | SPI chip select, active low, synchronised |
| spi_sck | input | 1 | SPI serial clock, mode 0, synchronised |
| spi_mosi | input | 1 | SPI serial data in, sampled on SCK rise |
| array_busy | input | 1 | High while a program/erase/write cycle runs |
| spi_miso | output | 1 | SPI serial data out for lock read-back |
| sector_inhibit | output | N_SECT | Per-sector block of program and erase |

## Verification
A correctly framed lock write can complete in the same cycle that `array_busy` is high. In that case the busy rule must win: no field may change and the write-enable latch must survive. The bench holds `array_busy` high across a full valid frame with the latch set. It then repeats the same frame with busy low and no new write enable. This shows that the first attempt left the latch intact and the second one applies. The sticky lock-down rule and a new write to the same sector are also made to meet. This shows the frozen field and the clearing of the latch within one commit.

// File: rtl/spi_lock_pkg.sv
package spi_lock_pkg;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRLOCK = 8'hE5;
    localparam logic [7:0] OP_RDLOCK = 8'hE8;

    localparam int OPC_BITS      = 8;
    localparam int WR_FRAME_BITS = 40;
    localparam int RD_HDR_BITS   = 32;
    localparam int CNT_W         = 6;

    localparam int BIT_WLOCK = 0;
    localparam int BIT_LDOWN = 1;

    typedef logic [1:0] lock_fld_t;
endpackage

// File: rtl/spi_lock_shifter.sv
module spi_lock_shifter
    import spi_lock_pkg::*;
#(
    parameter int N_SECT   = 16,
    parameter int SECT_LSB = 16,
    localparam int SW      = $clog2(N_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    output logic             cs_rise,
    output logic             sck_fall,
    output logic [CNT_W-1:0] frame_len,
    output logic [7:0]       opcode,
    output logic [SW-1:0]    wr_sector,
    output lock_fld_t        wr_data,
    output logic             rd_load,
    output logic [SW-1:0]    rd_sector
);
    localparam int FRM_W = OPC_BITS + SECT_LSB + SW;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             cs_s;
        logic             sck_s;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       opc;
        logic [FRM_W-1:0] frm;
    } shf_t;

    shf_t q, d;
    logic sck_rise;

    always_comb begin
        sck_rise = !cs_n && sck && !q.sck_s;
        sck_fall = !cs_n && !sck && q.sck_s;
        cs_rise  = cs_n && !q.cs_s;

        d       = q;
        d.cs_s  = cs_n;
        d.sck_s = sck;
        if (cs_n) begin
            d.cnt = '0;
            d.opc = '0;
        end else if (sck_rise) begin
            d.frm = {q.frm[FRM_W-2:0], mosi};
            if (q.cnt != CNT_MAX)
                d.cnt = q.cnt + CNT_W'(1);
            if (q.cnt == CNT_W'(OPC_BITS - 1))
                d.opc = {q.frm[OPC_BITS-2:0], mosi};
        end

        rd_load   = sck_rise && (q.cnt == CNT_W'(RD_HDR_BITS - 1)) && (q.opc == OP_RDLOCK);
        rd_sector = q.frm[SECT_LSB-1 +: SW];
        wr_sector = q.frm[OPC_BITS+SECT_LSB +: SW];
        wr_data   = q.frm[1:0];
        frame_len = q.cnt;
        opcode    = q.opc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_s <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spi_lock_store.sv
module spi_lock_store
    import spi_lock_pkg::*;
#(
    parameter int N_SECT = 16,
    localparam int SW    = $clog2(N_SECT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_rise,
    input  logic [CNT_W-1:0]       frame_len,
    input  logic [7:0]             opcode,
    input  logic [SW-1:0]          wr_sector,
    input  lock_fld_t              wr_data,
    input  logic                   busy,
    output logic [N_SECT-1:0][1:0] lock_fields,
    output logic                   wel,
    output logic [N_SECT-1:0]      inhibit
);
    typedef struct packed {
        logic                   wel;
        logic [N_SECT-1:0][1:0] lock;
    } sto_t;

    sto_t q, d;
    logic              wr_ok;
    logic              wren_ok;
    logic [N_SECT-1:0] upd;

    assign wren_ok = cs_rise && (opcode == OP_WREN) && (frame_len == CNT_W'(OPC_BITS));
    assign wr_ok   = cs_rise && (opcode == OP_WRLOCK) && (frame_len == CNT_W'(WR_FRAME_BITS))
                     && q.wel && !busy;

    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
        assign upd[i]     = wr_ok && (wr_sector == SW'(i)) && !q.lock[i][BIT_LDOWN];
        assign inhibit[i] = q.lock[i][BIT_WLOCK];
    end

    always_comb begin
        d = q;
        if (wren_ok)
            d.wel = 1'b1;
        if (wr_ok)
            d.wel = 1'b0;
        for (int i = 0; i < N_SECT; i++) begin
            if (upd[i])
                d.lock[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign lock_fields = q.lock;
    assign wel         = q.wel;
endmodule

// File: rtl/spi_sector_lock.sv
module spi_sector_lock
    import spi_lock_pkg::*;
#(
    parameter int N_SECT   = 16,
    parameter int SECT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              array_busy,
    output logic              spi_miso,
    output logic [N_SECT-1:0] sector_inhibit
);
    localparam int SW = $clog2(N_SECT);

    logic                   cs_rise;
    logic                   sck_fall;
    logic [CNT_W-1:0]       frame_len;
    logic [7:0]             opcode;
    logic [SW-1:0]          wr_sector;
    lock_fld_t              wr_data;
    logic                   rd_load;
    logic [SW-1:0]          rd_sector;
    logic [N_SECT-1:0][1:0] lock_fields;
    logic                   wel;

    spi_lock_shifter #(.N_SECT(N_SECT), .SECT_LSB(SECT_LSB)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .cs_rise   (cs_rise),
        .sck_fall  (sck_fall),
        .frame_len (frame_len),
        .opcode    (opcode),
        .wr_sector (wr_sector),
        .wr_data   (wr_data),
        .rd_load   (rd_load),
        .rd_sector (rd_sector)
    );

    spi_lock_store #(.N_SECT(N_SECT)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_rise     (cs_rise),
        .frame_len   (frame_len),
        .opcode      (opcode),
        .wr_sector   (wr_sector),
        .wr_data     (wr_data),
        .busy        (array_busy),
        .lock_fields (lock_fields),
        .wel         (wel),
        .inhibit     (sector_inhibit)
    );

    typedef struct packed {
        logic [7:0] sr;
        logic       miso;
    } rd_t;

    rd_t rd_q, rd_d;

    always_comb begin
        rd_d = rd_q;
        if (spi_cs_n) begin
            rd_d = '0;
        end else if (rd_load) begin
            rd_d.sr = {6'b000000, lock_fields[rd_sector]};
        end else if (sck_fall) begin
            rd_d.miso = rd_q.sr[7];
            rd_d.sr   = {rd_q.sr[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign spi_miso = rd_q.miso;
endmodule

// File: rtl/spi_sector_lock_chk.sv
module spi_sector_lock_chk #(
    parameter int N_SECT = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   spi_cs_n,
    input logic                   array_busy,
    input logic                   spi_miso,
    input logic [N_SECT-1:0]      sector_inhibit,
    input logic [N_SECT-1:0][1:0] lock_fields,
    input logic                   wel
);
    AST_INHIBIT_HOLD_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |=> $stable(sector_inhibit)); // R7

    AST_BUSY_FREEZES_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        array_busy |=> $stable(lock_fields)); // R6

    AST_WEL_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_fields) |-> !wel); // R3

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso); // R9

    for (genvar i = 0; i < N_SECT; i++) begin : g_ld
        AST_LDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            lock_fields[i][1] |=> $stable(lock_fields[i])); // R8
    end
endmodule

bind spi_sector_lock spi_sector_lock_chk #(.N_SECT(N_SECT)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_cs_n       (spi_cs_n),
    .array_busy     (array_busy),
    .spi_miso       (spi_miso),
    .sector_inhibit (sector_inhibit),
    .lock_fields    (lock_fields),
    .wel            (wel)
);

// File: tb/spi_sector_lock_tb.sv
module spi_sector_lock_tb;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_sck = 1'b0;
    logic          spi_mosi = 1'b0;
    logic          array_busy = 1'b0;
    logic          spi_miso;
    logic [NS-1:0] sector_inhibit;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    logic [1:0] exp_lock [NS];
    bit         exp_wel;

    always #5 clk = ~clk;

    spi_sector_lock #(.N_SECT(NS), .SECT_LSB(16)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .spi_cs_n       (spi_cs_n),
        .spi_sck        (spi_sck),
        .spi_mosi       (spi_mosi),
        .array_busy     (array_busy),
        .spi_miso       (spi_miso),
        .sector_inhibit (sector_inhibit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] exp_inh();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = exp_lock[i][0];
        return v;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NS; i++) exp_lock[i] = 2'b00;
        exp_wel = 1'b0;
    endfunction

    function automatic void model_apply(input logic [7:0] op, input int n,
                                        input logic [23:0] addr, input logic [7:0] data,
                                        input bit busy);
        int sec;
        sec = int'(addr[19:16]);
        if (op == 8'h06 && n == 8) exp_wel = 1'b1;
        if (op == 8'hE5 && n == 40 && exp_wel && !busy) begin
            exp_wel = 1'b0;
            if (!exp_lock[sec][1]) exp_lock[sec] = data[1:0];
        end
    endfunction

    // compare per clock against the reference model (R7)
    always @(negedge clk) begin
        if (cmp_en)
            chk(sector_inhibit == exp_inh(), "R7 inhibit vs model",
                int'(sector_inhibit), int'(exp_inh()));
    end

    task automatic spi_xfer(input logic [47:0] v, input int n, input bit do_rd,
                            output logic [7:0] rd);
        rd = 8'h00;
        @(negedge clk) spi_cs_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk) spi_mosi = v[n-1-k];
            repeat (2) @(negedge clk);
            if (do_rd && k >= 32 && k < 40) rd = {rd[6:0], spi_miso};
            spi_sck = 1'b1;
            repeat (2) @(negedge clk);
            spi_sck = 1'b0;
        end
        @(negedge clk) cmp_en = 1'b0;
        @(negedge clk) begin
            spi_cs_n = 1'b1;
            spi_mosi = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op, input logic [23:0] addr,
                       input logic [7:0] data, input int n);
        logic [47:0] v;
        logic [39:0] full;
        logic [7:0]  dummy;
        full = {op, addr, data};
        if (n <= 40) v = {8'h00, full} >> (40 - n);
        else         v = {8'h00, full} << (n - 40);
        spi_xfer(v, n, 1'b0, dummy);
        model_apply(op, n, addr, data, array_busy);
        cmp_en = 1'b1;
    endtask

    task automatic wren();
        cmd(8'h06, 24'h0, 8'h0, 8);
    endtask

    task automatic rd_chk(input logic [23:0] addr, input string req);
        logic [7:0] got;
        logic [7:0] exp;
        spi_xfer({8'h00, 8'hE8, addr, 8'h00}, 40, 1'b1, got);
        exp = {6'b000000, exp_lock[int'(addr[19:16])]};
        chk(got == exp, req, int'(got), int'(exp));
        chk(spi_miso == 1'b0, "R9 miso idle after read", int'(spi_miso), 0);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sector_inhibit == '0, "R1 inhibit after reset", int'(sector_inhibit), 0);
        chk(spi_miso == 1'b0, "R1 miso after reset", int'(spi_miso), 0);
        cmp_en = 1'b1;
        rd_chk(24'h030000, "R1 read sector 3 after reset");

        // R4: write without latch
        cmd(8'hE5, 24'h020000, 8'h01, 40);
        rd_chk(24'h020000, "R4 no latch, sector 2 unchanged");

        // R2/R3/R11: latch then write, upper address bits ignored, reserved bits dropped
        wren();
        cmd(8'hE5, 24'hF2ABCD, 8'hFD, 40);
        rd_chk(24'h02FFFF, "R3 R11 sector 2 reads 01");
        chk(sector_inhibit[2] == 1'b1, "R7 inhibit sector 2", int'(sector_inhibit[2]), 1);

        // R3: latch cleared after write
        cmd(8'hE5, 24'h050000, 8'h01, 40);
        rd_chk(24'h050000, "R3 latch cleared, sector 5 unchanged");

        // R6: busy at commit, latch kept
        wren();
        array_busy = 1'b1;
        cmd(8'hE5, 24'h051234, 8'h01, 40);
        array_busy = 1'b0;
        rd_chk(24'h050000, "R6 busy write ignored");
        cmd(8'hE5, 24'h051234, 8'h01, 40);
        rd_chk(24'h050000, "R6 latch kept through busy write");

        // R5: wrong frame lengths, latch kept
        wren();
        cmd(8'hE5, 24'h060000, 8'h01, 39);
        rd_chk(24'h060000, "R5 short frame ignored");
        cmd(8'hE5, 24'h060000, 8'h01, 41);
        rd_chk(24'h060000, "R5 long frame ignored");
        cmd(8'hE5, 24'h060000, 8'h01, 40);
        rd_chk(24'h060000, "R5 latch kept, exact frame applies");

        // R10: unknown opcode leaves latch and fields
        wren();
        cmd(8'h5A, 24'h070000, 8'h01, 40);
        rd_chk(24'h070000, "R10 unknown opcode ignored");
        cmd(8'hE5, 24'h070000, 8'h01, 40);
        rd_chk(24'h070000, "R10 latch kept across unknown opcode");

        // R8: lock-down freezes field; latch still clears
        wren();
        cmd(8'hE5, 24'h090000, 8'h03, 40);
        wren();
        cmd(8'hE5, 24'h090000, 8'h00, 40);
        rd_chk(24'h090000, "R8 frozen field reads 03");
        cmd(8'hE5, 24'h010000, 8'h01, 40);
        rd_chk(24'h010000, "R8 latch cleared by frozen write");

        // R7/R9: lock-down only, no inhibit
        wren();
        cmd(8'hE5, 24'h040000, 8'h02, 40);
        rd_chk(24'h040000, "R9 read sector 4 reads 02");
        chk(sector_inhibit[4] == 1'b0, "R7 lock-down alone no inhibit",
            int'(sector_inhibit[4]), 0);

        // R1/R8: reset clears everything including lock-down
        cmp_en = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(sector_inhibit == '0, "R1 inhibit after second reset", int'(sector_inhibit), 0);
        cmp_en = 1'b1;
        rd_chk(24'h090000, "R8 lock-down cleared by reset");
        wren();
        cmd(8'hE5, 24'h090000, 8'h01, 40);
        rd_chk(24'h090000, "R8 sector writable after reset");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule